// File: doc/BRIEF.md
# Debug and Cache Control Command Decoder

This block sits behind a 32-bit command port that never stalls. Every word written to the port is decoded as a command. The opcode sits in the three lowest bits, and a 4-bit index sits in the top nibble. Some commands only choose what the read path returns from then on: a data-cache register, an instruction-cache register, or one of the local registers. The local registers are a free-running cycle counter, a version constant and the interrupt enable register.

The remaining commands have side effects. One writes the interrupt enable bits. Two pass the whole word to the data-cache or instruction-cache controller, where index 0 means "invalidate the line at this address". One loads a 16-bit holding register. One sends a 32-bit debug word, made of the holding register and 16 bits of the command, onto a separate output stream.

The block also raises an interrupt from the status of the outgoing and incoming FIFOs, gated by the enable bits. Software uses the port as a put followed by a get: write a selecting command, then read the result.

Top module: `dbgctl_cmd_decoder`

## Requirements
- R1: After reset the read data is zero, the interrupt enable bits are zero, `irq_o` is low, and no forward or debug strobe is active.
- R2: A command with opcode 0 (or opcode 1) makes `dc_reg_idx_o` (or `ic_reg_idx_o`) equal to bits [31:28] of the command from the next cycle on. From then, `cmd_rdata_o` follows `dc_reg_rdata_i` (or `ic_reg_rdata_i`) until the next command.
- R3: Opcode 2 with index 0 selects the cycle counter. The counter is zero in reset, adds one on every clock edge after reset is released, wraps at 2^CNT_W, and is read zero-extended. Its value is live, not a snapshot taken at selection.
- R4: Opcode 2 with index 1 reads the VERSION parameter. Index 2 reads the enable register, with the output-ready bit at bit 8, the input-waiting bit at bit 9 and all other bits zero. Indices 3 to 15 read zero.
- R5: Opcode 3 loads the output-ready enable from bit 8 and the input-waiting enable from bit 9 of the command. All other command bits have no effect on the enable register.
- R6: `irq_o` is registered. It is high one cycle after a cycle in which either the output-ready enable is set and both `tx_empty_i` and `tx_ready_i` are high, or the input-waiting enable is set and `rx_avail_i` is high. Otherwise it is low.
- R7: Opcode 4 (or opcode 5) raises `dc_fwd_valid_o` (or `ic_fwd_valid_o`) for exactly the next cycle, with the unchanged command word on the forward word output. No other opcode raises either strobe.
- R8: Opcode 6 loads a holding register from command bits [23:8]. Opcode 7 raises `dbg_valid_o` for the next cycle with `dbg_word_o` = {holding register, command bits [23:8]}. Other opcodes leave the holding register unchanged.
- R9: Reads that follow a command with opcode 3 to 7 return zero. Commands are accepted on every cycle that `cmd_wr_i` is high, including back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command word |
| cmd_rdata_o | output | 32 | Read data selected by the last command |
| dc_reg_idx_o | output | 4 | Data-cache register index |
| dc_reg_rdata_i | input | 32 | Data-cache register value |
| ic_reg_idx_o | output | 4 | Instruction-cache register index |
| ic_reg_rdata_i | input | 32 | Instruction-cache register value |
| dc_fwd_valid_o | output | 1 | Data-cache forward strobe |
| dc_fwd_word_o | output | 32 | Word forwarded to the data cache |
| ic_fwd_valid_o | output | 1 | Instruction-cache forward strobe |
| ic_fwd_word_o | output | 32 | Word forwarded to the instruction cache |
| dbg_valid_o | output | 1 | Debug word strobe |
| dbg_word_o | output | 32 | Debug word |
| tx_empty_i | input | 1 | Outgoing FIFO is empty |
| tx_ready_i | input | 1 | Outgoing FIFO accepts a put |
| rx_avail_i | input | 1 | Incoming FIFO holds data |
| irq_o | output | 1 | Interrupt request |

## Verification
Every opcode is tried with all sixteen index values. The cache register models return a value that encodes both the cache and the index, so a wrong source, a stale index or a zero leaking through can each be told apart. The counter is read over more than one wrap of an 8-bit configuration, which separates a live value from a snapshot and shows whether it wraps correctly. The interrupt is swept over all four enable settings against all eight FIFO status patterns. The enable, forward and debug commands carry unrelated bits set in their other fields, which shows that those bits have no effect.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned IDX_LSB = WORD_W - IDX_W;
  localparam int unsigned PAY_LSB = 8;
  localparam int unsigned IEN_LSB = 8;

  typedef enum logic [OP_W-1:0] {
    OP_RD_DC    = 3'd0,
    OP_RD_IC    = 3'd1,
    OP_RD_LOC   = 3'd2,
    OP_SET_IEN  = 3'd3,
    OP_FWD_DC   = 3'd4,
    OP_FWD_IC   = 3'd5,
    OP_LOAD_HLD = 3'd6,
    OP_EMIT     = 3'd7
  } dbg_op_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DC   = 2'd1,
    SRC_IC   = 2'd2,
    SRC_LOC  = 2'd3
  } rd_src_e;

  typedef struct packed {
    rd_src_e          src;
    logic [IDX_W-1:0] idx;
  } rd_sel_t;

  localparam logic [IDX_W-1:0] LOC_CNT = 4'd0;
  localparam logic [IDX_W-1:0] LOC_VER = 4'd1;
  localparam logic [IDX_W-1:0] LOC_IEN = 4'd2;
endpackage

// File: rtl/dbgctl_cycle_cnt.sv
module dbgctl_cycle_cnt
  import dbgctl_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [WORD_W-1:0] cnt_word_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb begin
    cnt_word_o             = '0;
    cnt_word_o[CNT_W-1:0]  = cnt_q;
  end
endmodule

// File: rtl/dbgctl_irq_ctl.sv
module dbgctl_irq_ctl
  import dbgctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  dbg_op_e           op_i,
  input  logic [1:0]        ien_bits_i,
  input  logic              tx_empty_i,
  input  logic              tx_ready_i,
  input  logic              rx_avail_i,
  output logic [WORD_W-1:0] ien_word_o,
  output logic              irq_o
);
  logic [1:0] ien_q, ien_d;
  logic       ien_en;
  logic       irq_q, irq_d;

  always_comb begin
    ien_en = wr_en_i && (op_i == OP_SET_IEN);
    ien_d  = ien_bits_i;
    irq_d  = (ien_q[0] && tx_empty_i && tx_ready_i) || (ien_q[1] && rx_avail_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
    end else if (ien_en) begin
      ien_q <= ien_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  always_comb begin
    ien_word_o                       = '0;
    ien_word_o[IEN_LSB+1:IEN_LSB]    = ien_q;
    irq_o                            = irq_q;
  end
endmodule

// File: rtl/dbgctl_emit.sv
module dbgctl_emit
  import dbgctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  dbg_op_e           op_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              dc_valid_o,
  output logic              ic_valid_o,
  output logic [WORD_W-1:0] fwd_word_o,
  output logic              dbg_valid_o,
  output logic [WORD_W-1:0] dbg_word_o
);
  logic [HALF_W-1:0] pay;
  logic [HALF_W-1:0] hold_q;
  logic              hold_en;
  logic              dc_d, ic_d, dbg_d, fwd_en;
  logic              dc_q, ic_q, dbg_q;
  logic [WORD_W-1:0] fwd_q, dbgw_q, dbgw_d;

  always_comb begin
    pay     = wdata_i[PAY_LSB+HALF_W-1:PAY_LSB];
    hold_en = wr_en_i && (op_i == OP_LOAD_HLD);
    dc_d    = wr_en_i && (op_i == OP_FWD_DC);
    ic_d    = wr_en_i && (op_i == OP_FWD_IC);
    dbg_d   = wr_en_i && (op_i == OP_EMIT);
    fwd_en  = dc_d || ic_d;
    dbgw_d  = {hold_q, pay};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_q  <= 1'b0;
      ic_q  <= 1'b0;
      dbg_q <= 1'b0;
    end else begin
      dc_q  <= dc_d;
      ic_q  <= ic_d;
      dbg_q <= dbg_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (hold_en) hold_q <= pay;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fwd_q <= '0;
    else if (fwd_en) fwd_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dbgw_q <= '0;
    else if (dbg_d) dbgw_q <= dbgw_d;
  end

  always_comb begin
    dc_valid_o  = dc_q;
    ic_valid_o  = ic_q;
    fwd_word_o  = fwd_q;
    dbg_valid_o = dbg_q;
    dbg_word_o  = dbgw_q;
  end
endmodule

// File: rtl/dbgctl_rdsel.sv
module dbgctl_rdsel
  import dbgctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  dbg_op_e           op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] dc_rdata_i,
  input  logic [WORD_W-1:0] ic_rdata_i,
  input  logic [WORD_W-1:0] cnt_word_i,
  input  logic [WORD_W-1:0] ver_word_i,
  input  logic [WORD_W-1:0] ien_word_i,
  output logic [IDX_W-1:0]  sel_idx_o,
  output logic [WORD_W-1:0] rdata_o
);
  rd_sel_t sel_q, sel_d;

  always_comb begin
    sel_d.idx = idx_i;
    unique case (op_i)
      OP_RD_DC:  sel_d.src = SRC_DC;
      OP_RD_IC:  sel_d.src = SRC_IC;
      OP_RD_LOC: sel_d.src = SRC_LOC;
      default:   sel_d.src = SRC_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q.src <= SRC_NONE;
      sel_q.idx <= '0;
    end else if (wr_en_i) begin
      sel_q <= sel_d;
    end
  end

  always_comb begin
    sel_idx_o = sel_q.idx;
    rdata_o   = '0;
    unique case (sel_q.src)
      SRC_DC:  rdata_o = dc_rdata_i;
      SRC_IC:  rdata_o = ic_rdata_i;
      SRC_LOC: begin
        if      (sel_q.idx == LOC_CNT) rdata_o = cnt_word_i;
        else if (sel_q.idx == LOC_VER) rdata_o = ver_word_i;
        else if (sel_q.idx == LOC_IEN) rdata_o = ien_word_i;
        else                           rdata_o = '0;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dbgctl_cmd_decoder.sv
module dbgctl_cmd_decoder
  import dbgctl_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_wr_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] cmd_rdata_o,
  output logic [3:0]  dc_reg_idx_o,
  input  logic [31:0] dc_reg_rdata_i,
  output logic [3:0]  ic_reg_idx_o,
  input  logic [31:0] ic_reg_rdata_i,
  output logic        dc_fwd_valid_o,
  output logic [31:0] dc_fwd_word_o,
  output logic        ic_fwd_valid_o,
  output logic [31:0] ic_fwd_word_o,
  output logic        dbg_valid_o,
  output logic [31:0] dbg_word_o,
  input  logic        tx_empty_i,
  input  logic        tx_ready_i,
  input  logic        rx_avail_i,
  output logic        irq_o
);
  dbg_op_e           op;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] cnt_word, ien_word, fwd_word;
  logic [IDX_W-1:0]  sel_idx;

  always_comb begin
    op  = dbg_op_e'(cmd_wdata_i[OP_W-1:0]);
    idx = cmd_wdata_i[WORD_W-1:IDX_LSB];
  end

  dbgctl_cycle_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_word_o (cnt_word)
  );

  dbgctl_irq_ctl irq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (cmd_wr_i),
    .op_i       (op),
    .ien_bits_i (cmd_wdata_i[IEN_LSB+1:IEN_LSB]),
    .tx_empty_i (tx_empty_i),
    .tx_ready_i (tx_ready_i),
    .rx_avail_i (rx_avail_i),
    .ien_word_o (ien_word),
    .irq_o      (irq_o)
  );

  dbgctl_emit emit_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (cmd_wr_i),
    .op_i        (op),
    .wdata_i     (cmd_wdata_i),
    .dc_valid_o  (dc_fwd_valid_o),
    .ic_valid_o  (ic_fwd_valid_o),
    .fwd_word_o  (fwd_word),
    .dbg_valid_o (dbg_valid_o),
    .dbg_word_o  (dbg_word_o)
  );

  dbgctl_rdsel rdsel_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (cmd_wr_i),
    .op_i       (op),
    .idx_i      (idx),
    .dc_rdata_i (dc_reg_rdata_i),
    .ic_rdata_i (ic_reg_rdata_i),
    .cnt_word_i (cnt_word),
    .ver_word_i (VERSION),
    .ien_word_i (ien_word),
    .sel_idx_o  (sel_idx),
    .rdata_o    (cmd_rdata_o)
  );

  always_comb begin
    dc_reg_idx_o  = sel_idx;
    ic_reg_idx_o  = sel_idx;
    dc_fwd_word_o = fwd_word;
    ic_fwd_word_o = fwd_word;
  end
endmodule

// File: rtl/dbgctl_cmd_decoder_chk.sv
module dbgctl_cmd_decoder_chk #(
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_wr_i,
  input logic [31:0] cmd_wdata_i,
  input logic [31:0] cmd_rdata_o,
  input logic [3:0]  dc_reg_idx_o,
  input logic [31:0] dc_reg_rdata_i,
  input logic        dc_fwd_valid_o,
  input logic [31:0] dc_fwd_word_o,
  input logic        ic_fwd_valid_o,
  input logic [31:0] ic_fwd_word_o,
  input logic        dbg_valid_o,
  input logic [31:0] dbg_word_o,
  input logic        tx_empty_i,
  input logic        tx_ready_i,
  input logic        rx_avail_i,
  input logic        irq_o
);
  a_r7_dc_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_wdata_i[2:0] == 3'd4 |=> dc_fwd_valid_o && dc_fwd_word_o == $past(cmd_wdata_i));
  a_r7_dc_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_wr_i && cmd_wdata_i[2:0] == 3'd4) |=> !dc_fwd_valid_o);
  a_r7_ic_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_wdata_i[2:0] == 3'd5 |=> ic_fwd_valid_o && ic_fwd_word_o == $past(cmd_wdata_i));
  a_r7_ic_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_wr_i && cmd_wdata_i[2:0] == 3'd5) |=> !ic_fwd_valid_o);
  a_r8_emit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_wdata_i[2:0] == 3'd7 |=> dbg_valid_o && dbg_word_o[15:0] == $past(cmd_wdata_i[23:8]));
  a_r8_emit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_wr_i && cmd_wdata_i[2:0] == 3'd7) |=> !dbg_valid_o);
  a_r7_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dc_fwd_valid_o, ic_fwd_valid_o, dbg_valid_o}));
  a_r4_version: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_wdata_i[2:0] == 3'd2 && cmd_wdata_i[31:28] == 4'd1 |=> cmd_rdata_o == VERSION);
  a_r9_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_wdata_i[2:0] >= 3'd3 |=> cmd_rdata_o == 32'd0);
  a_r2_dc_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_wdata_i[2:0] == 3'd0 |=>
      dc_reg_idx_o == $past(cmd_wdata_i[31:28]) && cmd_rdata_o == dc_reg_rdata_i);
  a_r6_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((tx_empty_i && tx_ready_i) || rx_avail_i));
endmodule

bind dbgctl_cmd_decoder dbgctl_cmd_decoder_chk #(.VERSION(VERSION)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_wr_i       (cmd_wr_i),
  .cmd_wdata_i    (cmd_wdata_i),
  .cmd_rdata_o    (cmd_rdata_o),
  .dc_reg_idx_o   (dc_reg_idx_o),
  .dc_reg_rdata_i (dc_reg_rdata_i),
  .dc_fwd_valid_o (dc_fwd_valid_o),
  .dc_fwd_word_o  (dc_fwd_word_o),
  .ic_fwd_valid_o (ic_fwd_valid_o),
  .ic_fwd_word_o  (ic_fwd_word_o),
  .dbg_valid_o    (dbg_valid_o),
  .dbg_word_o     (dbg_word_o),
  .tx_empty_i     (tx_empty_i),
  .tx_ready_i     (tx_ready_i),
  .rx_avail_i     (rx_avail_i),
  .irq_o          (irq_o)
);

// File: tb/dbgctl_cmd_decoder_tb_top.sv
module dbgctl_cmd_decoder_tb_top;
  localparam int unsigned TB_CNT_W   = 8;
  localparam logic [31:0] TB_VERSION = 32'h0003_0105;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr;
  logic [31:0] cmd_wdata;
  logic [31:0] cmd_rdata;
  logic [3:0]  dc_idx, ic_idx;
  logic [31:0] dc_rdata, ic_rdata;
  logic        dc_v, ic_v, dbg_v;
  logic [31:0] dc_w, ic_w, dbg_w;
  logic        tx_empty, tx_ready, rx_avail;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  assign dc_rdata = 32'hDC00_0000 | {28'd0, dc_idx};
  assign ic_rdata = 32'h1C00_0000 | {28'd0, ic_idx};

  always @(posedge clk) begin
    if (!rst_n) edges = 0;
    else        edges = edges + 1;
  end

  dbgctl_cmd_decoder #(.CNT_W(TB_CNT_W), .VERSION(TB_VERSION)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
    .cmd_rdata_o(cmd_rdata), .dc_reg_idx_o(dc_idx), .dc_reg_rdata_i(dc_rdata),
    .ic_reg_idx_o(ic_idx), .ic_reg_rdata_i(ic_rdata),
    .dc_fwd_valid_o(dc_v), .dc_fwd_word_o(dc_w),
    .ic_fwd_valid_o(ic_v), .ic_fwd_word_o(ic_w),
    .dbg_valid_o(dbg_v), .dbg_word_o(dbg_w),
    .tx_empty_i(tx_empty), .tx_ready_i(tx_ready), .rx_avail_i(rx_avail), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] idx, input logic [15:0] pay, input logic [2:0] op);
    return {idx, 4'hA, pay, 5'h15, op};
  endfunction

  task automatic wr(input logic [31:0] w);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(posedge clk); @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = 32'h0;
  endtask

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0;
    tx_empty = 1'b0; tx_ready = 1'b0; rx_avail = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: state right after reset
    check("R1 rdata", cmd_rdata, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 strobes", {29'd0, dc_v, ic_v, dbg_v}, 32'd0);
    wr(mk(4'd2, 16'h0000, 3'd2));
    check("R1 ien", cmd_rdata, 32'd0);

    // R3: counter from reset, live, with wrap
    wr(mk(4'd0, 16'h0000, 3'd2));
    for (int k = 0; k < 300; k++) begin
      check("R3 counter", cmd_rdata, edges % 256);
      @(negedge clk);
    end

    // R2: cache register selection, all indices
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 16; i++) begin
        wr(mk(4'(i), 16'hFFFF, 3'(c)));
        if (c == 0) begin
          check("R2 dc idx", {28'd0, dc_idx}, i);
          check("R2 dc read", cmd_rdata, 32'hDC00_0000 | i);
        end else begin
          check("R2 ic idx", {28'd0, ic_idx}, i);
          check("R2 ic read", cmd_rdata, 32'h1C00_0000 | i);
        end
      end
    end

    // R4: local registers
    for (int i = 1; i < 16; i++) begin
      wr(mk(4'(i), 16'hFFFF, 3'd2));
      if (i == 1)      check("R4 version", cmd_rdata, TB_VERSION);
      else if (i == 2) check("R4 ien", cmd_rdata, 32'd0);
      else             check("R4 unused", cmd_rdata, 32'd0);
    end

    // R5: enable register, other bits ignored
    for (int v = 0; v < 4; v++) begin
      wr((32'hF5A5_A4FB & ~32'h0000_0307) | (32'(v) << 8) | 32'd3);
      check("R9 after set", cmd_rdata, 32'd0);
      wr(mk(4'd2, 16'h0000, 3'd2));
      check("R5 ien read", cmd_rdata, 32'(v) << 8);
    end

    // R6: interrupt over all enables and FIFO patterns
    for (int v = 0; v < 4; v++) begin
      wr(32'(v) << 8 | 32'd3);
      for (int s = 0; s < 8; s++) begin
        tx_empty = s[0]; tx_ready = s[1]; rx_avail = s[2];
        @(posedge clk); @(negedge clk);
        check("R6 irq", {31'd0, irq},
              {31'd0, (v[0] && s[0] && s[1]) || (v[1] && s[2])});
      end
    end
    tx_empty = 1'b0; tx_ready = 1'b0; rx_avail = 1'b0;

    // R7: forwarding to the caches
    for (int i = 0; i < 16; i++) begin
      logic [31:0] w4, w5;
      w4 = {4'(i), 28'h123_4560} | 32'd4;
      w5 = {4'(i), 28'hBEE_F008} | 32'd5;
      cmd_wr = 1'b1; cmd_wdata = w4;
      @(posedge clk); @(negedge clk);
      check("R7 dc strobe", {30'd0, dc_v, ic_v}, 32'd2);
      check("R7 dc word", dc_w, w4);
      check("R9 after fwd", cmd_rdata, 32'd0);
      cmd_wdata = w5;
      @(posedge clk); @(negedge clk);
      cmd_wr = 1'b0;
      check("R7 ic strobe", {30'd0, dc_v, ic_v}, 32'd1);
      check("R7 ic word", ic_w, w5);
      @(posedge clk); @(negedge clk);
      check("R7 strobe ends", {29'd0, dc_v, ic_v, dbg_v}, 32'd0);
    end

    // R8: holding register and debug words
    for (int i = 0; i < 8; i++) begin
      logic [15:0] h, l;
      h = 16'h1111 * 16'(i + 1);
      l = 16'hF00D ^ 16'(i * 257);
      wr(mk(4'(i), h, 3'd6));
      check("R8 no emit on load", {31'd0, dbg_v}, 32'd0);
      wr(mk(4'(15 - i), 16'hAAAA, 3'd4));
      wr(mk(4'(i), l, 3'd7));
      check("R8 emit strobe", {31'd0, dbg_v}, 32'd1);
      check("R8 emit word", dbg_w, {h, l});
      check("R9 after emit", cmd_rdata, 32'd0);
      wr(mk(4'(i), ~l, 3'd7));
      check("R8 hold kept", dbg_w, {h, ~l});
    end

    // R9: back-to-back commands and zero reads after opcodes 3..7
    cmd_wr = 1'b1; cmd_wdata = mk(4'd3, 16'd0, 3'd0);
    @(posedge clk); @(negedge clk);
    check("R9 b2b first", cmd_rdata, 32'hDC00_0003);
    cmd_wdata = mk(4'd5, 16'd0, 3'd1);
    @(posedge clk); @(negedge clk);
    cmd_wr = 1'b0;
    check("R9 b2b second", cmd_rdata, 32'h1C00_0005);
    for (int o = 3; o < 8; o++) begin
      for (int i = 0; i < 16; i++) begin
        wr(mk(4'd9, 16'd0, 3'd1));
        wr({4'(i), 25'h0, 3'(o)});
        check("R9 zero read", cmd_rdata, 32'd0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule